// File: doc/BRIEF.md
# SPI Port with Master/Slave Role Arbitration

This block is a byte-wide SPI port built around a single 8-bit shift register that serves both roles. A small control register holds an enable, an ignore-select and a master bit. From these bits, and from the level on the active-low select input, the block works out its role. It then sets the direction of every pin through separate output enables, so that the pads can be shared with general-purpose use or with other SPI devices on the same bus.

In the master role the block generates SCLK at one quarter of the system clock. It sends the byte MSB first on MOSI and gathers the returning byte from MISO. In the slave role it follows an external SCLK and SCLK, MOSI and the select input pass through two-flop synchronisers. It samples MOSI on rising SCLK and changes MISO on falling SCLK. While select is honoured, an external device that pulls the select line low takes the master role away. The master bit is cleared, the transfer in progress is abandoned and a sticky mode-fault flag records the event.

A byte is written through the parallel port. In master mode this write starts a transfer. In slave mode it preloads the byte to be returned. The received byte and a completion flag are presented in parallel.

Top module: `spi_role_port`

## Requirements
- R1: After reset the enable, ignore-select and master bits, the mode-fault flag and the completion flag are all 0, and no output enable is asserted.
- R2: While the enable bit is 0, the sclk_oe, mosi_oe and miso_oe outputs are all 0. A byte write starts nothing and leaves done_o unchanged, and a low select input neither clears the master bit nor sets the fault flag.
- R3: In master mode (enable=1, master=1), sclk_oe and mosi_oe are 1 and miso_oe is 0. Between transfers sclk_o idles at 0 and mosi_o idles at 1.
- R4: A master transfer shifts out the written byte MSB first on mosi_o and gives 8 rising sclk_o edges. Each sclk_o period is 4 system clocks. MISO is sampled on each rising edge. done_o rises on the 30th clock after the clock that accepted the write, with rx_data holding the received byte.
- R5: A selected slave (enable=1, master=0, and either select low or ignore-select=1) has miso_oe=1 and sclk_oe=mosi_oe=0. It returns the preloaded byte MSB first on miso_o, changing it after each falling SCLK, and captures MOSI on each rising SCLK into rx_data.
- R6: An unselected slave (enable=1, ignore-select=0, master=0, select high) has miso_oe=0 and shifts nothing, so done_o stays 0.
- R7: With enable=1, ignore-select=0 and master=1, a low select input clears the master bit and sets fault_o three clocks after the input falls. It aborts any transfer, returns sclk_o low and makes the block a selected slave.
- R8: fault_o stays set until a fault_clr pulse. When a new fault and fault_clr fall in the same clock, the set wins.
- R9: With ignore-select=1 the select input has no effect: a master keeps its role and no fault is flagged, and a slave acts as selected.
- R10: done_o sets when the eighth rising SCLK edge of a byte has been captured, and a byte write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Load the three control bits |
| ctl_en | input | 1 | Enable bit to load |
| ctl_ign_ss | input | 1 | Ignore-select bit to load |
| ctl_master | input | 1 | Master bit to load |
| master_o | output | 1 | Current master bit |
| fault_o | output | 1 | Sticky mode-fault flag |
| fault_clr | input | 1 | Clear pulse for the fault flag |
| tx_wr | input | 1 | Byte write strobe |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last byte received |
| done_o | output | 1 | Transfer-complete flag |
| sclk_i | input | 1 | SCLK from the pad |
| sclk_o | output | 1 | SCLK to the pad |
| sclk_oe | output | 1 | SCLK output enable |
| mosi_i | input | 1 | MOSI from the pad |
| mosi_o | output | 1 | MOSI to the pad |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the pad |
| miso_o | output | 1 | MISO to the pad |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The fault flag can be set by a new mode fault in the same clock in which fault_clr arrives. The bench provokes this exactly. It first clears the flag with the select input held low, then writes the master bit and raises fault_clr on the very next clock, which is the clock where the demotion fires. It judges the result by requiring fault_o=1 and master_o=0 afterwards. A second collision, a select drop in the middle of a master transfer, is judged by an aborted transfer, sclk_o back at 0 and the pin enables turned around to the slave pattern.

// File: rtl/spi_role_port.sv
module spi_role_port #(
  parameter int W    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic         ctl_en,
  input  logic         ctl_ign_ss,
  input  logic         ctl_master,
  output logic         master_o,
  output logic         fault_o,
  input  logic         fault_clr,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_data,
  output logic [W-1:0] rx_data,
  output logic         done_o,
  input  logic         sclk_i,
  output logic         sclk_o,
  output logic         sclk_oe,
  input  logic         mosi_i,
  output logic         mosi_o,
  output logic         mosi_oe,
  input  logic         miso_i,
  output logic         miso_o,
  output logic         miso_oe,
  input  logic         ss_n_i
);
  localparam int CW = $clog2(W);
  localparam int PW = $clog2(2 * HALF);
  localparam logic [PW-1:0] RISE = PW'(HALF - 1);
  localparam logic [PW-1:0] FALL = PW'(2 * HALF - 1);

  logic en_q, ign_q, mst_q, fault_q, done_q, busy_q, sclk_q, mosi_q, miso_q;
  logic [W-1:0]  sh_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ph_q;
  logic [1:0]    sclk_sy, mosi_sy, ss_sy;
  logic          sclk_d;

  wire ss_s     = ss_sy[1];
  wire sclk_s   = sclk_sy[1];
  wire mosi_s   = mosi_sy[1];
  wire is_mst   = en_q & mst_q;
  wire selected = en_q & ~mst_q & (ign_q | ~ss_s);
  wire mfault   = en_q & ~ign_q & mst_q & ~ss_s;
  wire s_rise   = sclk_s & ~sclk_d;
  wire s_fall   = ~sclk_s & sclk_d;
  wire last     = cnt_q == CW'(W - 1);
  wire [CW-1:0] cnt_nx = last ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0; mosi_sy <= '0; ss_sy <= '1; sclk_d <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      sclk_d  <= sclk_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; ign_q <= 1'b0; mst_q <= 1'b0; fault_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q <= ctl_en; ign_q <= ctl_ign_ss; mst_q <= ctl_master;
      end
      if (mfault) mst_q <= 1'b0;
      if (fault_clr) fault_q <= 1'b0;
      if (mfault) fault_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b1; miso_q <= 1'b0;
      done_q <= 1'b0; sh_q <= '0; rx_q <= '0; cnt_q <= '0; ph_q <= '0;
    end else if (!en_q || mfault) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; ph_q <= '0; cnt_q <= '0;
    end else if (mst_q) begin
      if (tx_wr && !busy_q) begin
        sh_q <= tx_data; mosi_q <= tx_data[W-1]; busy_q <= 1'b1;
        ph_q <= '0; cnt_q <= '0; done_q <= 1'b0;
      end else if (busy_q) begin
        ph_q <= (ph_q == FALL) ? '0 : ph_q + 1'b1;
        if (ph_q == RISE) begin
          sclk_q <= 1'b1;
          sh_q   <= {sh_q[W-2:0], miso_i};
          if (last) begin
            done_q <= 1'b1;
            rx_q   <= {sh_q[W-2:0], miso_i};
          end
        end
        if (ph_q == FALL) begin
          sclk_q <= 1'b0;
          mosi_q <= sh_q[W-1];
          cnt_q  <= cnt_nx;
          if (last) busy_q <= 1'b0;
        end
      end
    end else begin
      if (tx_wr) begin
        sh_q <= tx_data; miso_q <= tx_data[W-1]; cnt_q <= '0; done_q <= 1'b0;
      end else if (!selected) begin
        cnt_q <= '0;
      end else begin
        if (s_rise) begin
          sh_q  <= {sh_q[W-2:0], mosi_s};
          cnt_q <= cnt_nx;
          if (last) begin
            done_q <= 1'b1;
            rx_q   <= {sh_q[W-2:0], mosi_s};
          end
        end
        if (s_fall) miso_q <= sh_q[W-1];
      end
    end

  assign master_o = mst_q;
  assign fault_o  = fault_q;
  assign done_o   = done_q;
  assign rx_data  = rx_q;
  assign sclk_o   = sclk_q;
  assign sclk_oe  = is_mst;
  assign mosi_o   = busy_q ? mosi_q : 1'b1;
  assign mosi_oe  = is_mst;
  assign miso_o   = miso_q;
  assign miso_oe  = selected;

  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !sclk_oe && !mosi_oe && !miso_oe); // R2
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_o && mosi_o); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_oe && miso_oe)); // R5
  AST_UNSEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !ign_q && !mst_q && ss_s |-> !miso_oe); // R6
  AST_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    mfault |=> !mst_q && fault_q && !busy_q); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q && !fault_clr |=> fault_q); // R8
  AST_IGN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && ign_q && mst_q && !ctl_wr |=> mst_q && $stable(fault_q)); // R9
endmodule

// File: tb/test_spi_role_port.sv
`timescale 1ns/1ps
module test_spi_role_port;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_en = 0, ctl_ign_ss = 0, ctl_master = 0, fault_clr = 0;
  logic tx_wr = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic master_o, fault_o, done_o;
  logic sclk_i = 0, sclk_o, sclk_oe, mosi_i = 0, mosi_o, mosi_oe;
  logic miso_i, miso_o, miso_oe, ss_n_i = 1;
  logic [7:0] smod = 0, cap = 0;
  int n_chk = 0, n_bad = 0, n_rise = 0;

  always #2.5 clk = ~clk;

  spi_role_port i_spi_role_port (.*);

  assign miso_i = smod[7];
  always @(posedge sclk_o) begin cap <= {cap[6:0], mosi_o}; n_rise <= n_rise + 1; end
  always @(negedge sclk_o) smod <= {smod[6:0], 1'b0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_sel(input logic ign, input logic ss_n);
    return ign | ~ss_n;
  endfunction

  task automatic cfg(input logic en, input logic ign, input logic mst);
    @(negedge clk); ctl_wr = 1; ctl_en = en; ctl_ign_ss = ign; ctl_master = mst;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic m_xfer(input logic [7:0] d, input logic [7:0] sl);
    int t;
    @(negedge clk); smod = sl; n_rise = 0;
    wr(d);
    t = 1;
    while (!done_o && t < 60) begin @(negedge clk); if (!done_o) t++; end
    chk("R4 clocks to done", t, 30);
    repeat (4) @(negedge clk);
    chk("R4 rising edges", n_rise, 8);
    chk("R4 mosi byte", cap, d);
    chk("R4 rx byte", rx_data, sl);
    chk("R3 idle sclk/mosi", {sclk_o, mosi_o}, 2'b01);
  endtask

  task automatic s_xfer(input logic [7:0] d, input logic [7:0] md, input logic ss, input logic ign);
    logic [7:0] got, prev_rx;
    logic sel;
    sel = exp_sel(ign, ss);
    prev_rx = rx_data;
    wr(d);
    ss_n_i = ss;
    repeat (3) @(negedge clk);
    chk(sel ? "R5 miso_oe" : "R6 miso_oe", miso_oe, sel);
    for (int k = 7; k >= 0; k--) begin
      mosi_i = md[k];
      repeat (4) @(negedge clk);
      got[k] = miso_o;
      sclk_i = 1;
      repeat (4) @(negedge clk);
      sclk_i = 0;
    end
    repeat (6) @(negedge clk);
    if (sel) begin
      chk("R5 miso byte", got, d);
      chk("R5 rx byte", rx_data, md);
      chk("R10 done set", done_o, 1);
    end else begin
      chk("R6 no done", done_o, 0);
      chk("R6 rx unchanged", rx_data, prev_rx);
    end
    ss_n_i = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset flags", {master_o, fault_o, done_o}, 0);
    chk("R1 reset oe", {sclk_oe, mosi_oe, miso_oe}, 0);

    // R3 R4 master
    cfg(1, 0, 1);
    chk("R3 master oe", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
    chk("R3 idle", {sclk_o, mosi_o}, 2'b01);
    m_xfer(8'hA5, 8'h3C);
    m_xfer(8'h00, 8'hFF);
    m_xfer(8'hFF, 8'h00);
    for (int i = 0; i < 20; i++) m_xfer(8'($urandom), 8'($urandom));
    wr(8'h12);
    chk("R10 done cleared by write", done_o, 0);
    repeat (40) @(negedge clk);

    // R9 master ignores select
    cfg(1, 1, 1);
    ss_n_i = 0;
    repeat (6) @(negedge clk);
    chk("R9 master kept", {master_o, fault_o, sclk_oe}, 3'b101);
    m_xfer(8'h96, 8'h69);
    ss_n_i = 1;

    // R2 disabled
    cfg(0, 0, 1);
    ss_n_i = 0;
    repeat (6) @(negedge clk);
    chk("R2 oe released", {sclk_oe, mosi_oe, miso_oe}, 0);
    chk("R2 no demotion", {master_o, fault_o}, 2'b10);
    wr(8'h55);
    repeat (40) @(negedge clk);
    chk("R2 write ignored", {done_o, sclk_o}, 2'b10);
    ss_n_i = 1;

    // R7 mode fault mid-transfer
    cfg(1, 0, 1);
    repeat (4) @(negedge clk);
    @(negedge clk); smod = 8'h0F; tx_wr = 1; tx_data = 8'hC3;
    @(negedge clk); tx_wr = 0;
    repeat (9) @(negedge clk);
    ss_n_i = 0;
    repeat (2) @(negedge clk);
    chk("R7 not yet demoted", master_o, 1);
    @(negedge clk);
    chk("R7 demoted", {master_o, fault_o}, 2'b01);
    chk("R7 slave pins", {sclk_oe, mosi_oe, miso_oe, sclk_o}, 4'b0010);
    repeat (40) @(negedge clk);
    chk("R7 aborted", done_o, 0);
    @(negedge clk); fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    chk("R8 cleared", fault_o, 0);

    // R8 set wins over clear in the same clock
    @(negedge clk); ctl_wr = 1; ctl_en = 1; ctl_ign_ss = 0; ctl_master = 1;
    @(negedge clk); ctl_wr = 0; fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    chk("R8 set wins", {fault_o, master_o}, 2'b10);
    repeat (5) @(negedge clk);
    chk("R8 sticky", fault_o, 1);
    ss_n_i = 1;

    // R5 R6 slave
    cfg(1, 0, 0);
    repeat (4) @(negedge clk);
    chk("R6 unselected oe", {sclk_oe, mosi_oe, miso_oe}, 0);
    s_xfer(8'h81, 8'h7E, 0, 0);
    wr(8'h00);
    chk("R10 done cleared", done_o, 0);
    s_xfer(8'h5A, 8'hE7, 1, 0);
    cfg(1, 1, 0);
    s_xfer(8'h2D, 8'hB4, 1, 1);
    for (int i = 0; i < 10; i++) begin
      logic ign, ss;
      ign = 1'($urandom); ss = 1'($urandom);
      cfg(1, ign, 0);
      s_xfer(8'($urandom), 8'($urandom), ss, ign);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule